// File: doc/BRIEF.md
# Byte-Wide Port for a Double-Buffered 16-Bit Compare Register

This block lets an 8-bit CPU register bus load and read a 16-bit output compare value. The value has to update atomically, because a comparator watches all 16 bits on every clock. Software writes the upper byte first. That write lands only in a shared staging latch. The later lower-byte write merges the staged byte with the new data and commits the full word on a single clock edge.

The block holds two 16-bit registers. One is a compare buffer and the other is the active compare value that the comparator uses. A mode input picks the target of CPU accesses. With buffering off, commits and reads go to the active register. With buffering on, they go to the buffer, and the active register copies the buffer whenever an external update strobe fires.

Top module: `cmp16_byte_port`

## Requirements
- R1: A synchronous active-high reset clears the staging latch, the buffer, the active register and the read data register to zero on the next rising edge.
- R2: A write with byte select 1 (upper byte) loads only the staging latch. Neither the buffer nor the active register changes because of it.
- R3: With buffering off, a write with byte select 0 (lower byte) loads the active register with {staged byte, written byte} on that edge and leaves the buffer unchanged.
- R4: With buffering on, a lower-byte write loads the buffer with {staged byte, written byte}. The active register changes only through an update strobe.
- R5: With buffering on, an update strobe copies the buffer value held before the edge into the active register in one cycle. If a lower-byte write to the buffer falls in the same cycle, the active register receives the old buffer value. With buffering off, the update strobe has no effect.
- R6: A lower-byte write does not clear the staging latch. Several lower-byte writes in a row all reuse the last staged upper byte.
- R7: A read strobe captures, one edge later, the selected byte (select 0 lower, 1 upper) of the buffer when buffering is on, or of the active register when it is off. The staging latch is never read back. Read data holds between strobes.
- R8: Reads have no side effects. The buffer and the active register change only through a lower-byte write or a buffered update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_sel | input | 1 | Byte select: 0 lower byte, 1 upper byte |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| dbuf_en | input | 1 | Double buffering enable |
| upd_stb | input | 1 | Buffer-to-active transfer strobe |
| rd_data | output | 8 | Registered read data |
| cmp_buf | output | 16 | Compare buffer value |
| cmp_act | output | 16 | Active compare value |

## Verification
The assertions assume that every input is settled and free of X at each rising edge, and that reset is sampled synchronously. They also assume that a change of buffering mode takes effect on the same edge, with no handshake. The bench changes every input only at falling edges and releases reset before any access. It sweeps staged and written byte values in both modes, and it deliberately mixes update strobes with buffer writes and reads, so the ordering corner cases stay inside the defined behaviour.

// File: rtl/cmp16_pkg.sv
package cmp16_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/cmp16_stage.sv
module cmp16_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/cmp16_regs.sv
module cmp16_regs #(
  parameter int BYTE_W = 8,
  localparam int REG_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             dbuf,
  input  logic             upd,
  input  logic [REG_W-1:0] word,
  output logic [REG_W-1:0] bufr_q,
  output logic [REG_W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (rst)                 bufr_q <= '0;
    else if (commit && dbuf) bufr_q <= word;
  end

  always_ff @(posedge clk) begin
    if (rst)                  act_q <= '0;
    else if (commit && !dbuf) act_q <= word;
    else if (upd && dbuf)     act_q <= bufr_q;
  end
endmodule

// File: rtl/cmp16_rdmux.sv
module cmp16_rdmux #(
  parameter int BYTE_W = 8,
  localparam int REG_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              sel_hi,
  input  logic              dbuf,
  input  logic [REG_W-1:0]  bufr_q,
  input  logic [REG_W-1:0]  act_q,
  output logic [BYTE_W-1:0] rd_q
);
  logic [REG_W-1:0]  src;
  logic [BYTE_W-1:0] pick;

  always_comb begin
    src  = dbuf ? bufr_q : act_q;
    pick = sel_hi ? src[REG_W-1:BYTE_W] : src[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (rd) rd_q <= pick;
  end
endmodule

// File: rtl/cmp16_byte_port.sv
module cmp16_byte_port #(
  parameter int BYTE_W = 8,
  localparam int REG_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              dbuf_en,
  input  logic              upd_stb,
  output logic [BYTE_W-1:0] rd_data,
  output logic [REG_W-1:0]  cmp_buf,
  output logic [REG_W-1:0]  cmp_act
);
  import cmp16_pkg::*;

  logic              stage_ld;
  logic              commit;
  logic [BYTE_W-1:0] staged;
  logic [REG_W-1:0]  word;

  always_comb begin
    stage_ld = wr_en && (byte_sel_e'(byte_sel) == SEL_HI);
    commit   = wr_en && (byte_sel_e'(byte_sel) == SEL_LO);
    word     = {staged, wr_data};
  end

  cmp16_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .rst(rst), .load(stage_ld), .din(wr_data), .q(staged)
  );

  cmp16_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .commit(commit), .dbuf(dbuf_en), .upd(upd_stb),
    .word(word), .bufr_q(cmp_buf), .act_q(cmp_act)
  );

  cmp16_rdmux #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .rd(rd_en), .sel_hi(byte_sel), .dbuf(dbuf_en),
    .bufr_q(cmp_buf), .act_q(cmp_act), .rd_q(rd_data)
  );
endmodule

// File: rtl/cmp16_byte_port_chk.sv
module cmp16_byte_port_chk #(
  parameter int BYTE_W = 8,
  localparam int REG_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic              wr_en,
  input logic              rd_en,
  input logic              dbuf_en,
  input logic              upd_stb,
  input logic [BYTE_W-1:0] rd_data,
  input logic [REG_W-1:0]  cmp_buf,
  input logic [REG_W-1:0]  cmp_act,
  input logic [BYTE_W-1:0] staged
);
  logic lo_wr, hi_wr, xfer;
  always_comb begin
    lo_wr = wr_en && !byte_sel;
    hi_wr = wr_en && byte_sel;
    xfer  = upd_stb && dbuf_en;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cmp_buf == '0 && cmp_act == '0 && rd_data == '0 && staged == '0));

  a_r2_hi_only_stage: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !xfer) |=> ($stable(cmp_buf) && $stable(cmp_act)
                          && staged == $past(wr_data)));

  a_r3_direct_commit: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !dbuf_en) |=> (cmp_act == {$past(staged), $past(wr_data)}
                             && $stable(cmp_buf)));

  a_r4_buffer_commit: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && dbuf_en && !upd_stb) |=> (cmp_buf == {$past(staged), $past(wr_data)}
                                        && $stable(cmp_act)));

  a_r5_transfer: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (cmp_act == $past(cmp_buf)));

  a_r6_stage_kept: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(staged));

  a_r7_read_byte: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == ($past(byte_sel)
      ? ($past(dbuf_en) ? $past(cmp_buf[REG_W-1:BYTE_W]) : $past(cmp_act[REG_W-1:BYTE_W]))
      : ($past(dbuf_en) ? $past(cmp_buf[BYTE_W-1:0])     : $past(cmp_act[BYTE_W-1:0])))));

  a_r7_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!lo_wr && !xfer) |=> ($stable(cmp_buf) && $stable(cmp_act)));
endmodule

bind cmp16_byte_port cmp16_byte_port_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .byte_sel(byte_sel), .wr_data(wr_data), .wr_en(wr_en),
  .rd_en(rd_en), .dbuf_en(dbuf_en), .upd_stb(upd_stb), .rd_data(rd_data),
  .cmp_buf(cmp_buf), .cmp_act(cmp_act), .staged(staged)
);

// File: tb/cmp16_byte_port_test.sv
module cmp16_byte_port_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        byte_sel, wr_en, rd_en, dbuf_en, upd_stb;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [15:0] cmp_buf, cmp_act;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  m_stage;
  logic [15:0] m_buf, m_act;
  logic [7:0]  m_rd;

  always #10 clk = ~clk;

  cmp16_byte_port uut (
    .clk(clk), .rst(rst), .byte_sel(byte_sel), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .dbuf_en(dbuf_en), .upd_stb(upd_stb), .rd_data(rd_data),
    .cmp_buf(cmp_buf), .cmp_act(cmp_act)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit sel, input logic [7:0] d,
                      input bit r, input bit u, input string req);
    logic [15:0] src;
    wr_en = w; byte_sel = sel; wr_data = d; rd_en = r; upd_stb = u;
    src = dbuf_en ? m_buf : m_act;
    @(posedge clk);
    if (r) m_rd = sel ? src[15:8] : src[7:0];
    if (dbuf_en && u) m_act = m_buf;
    if (w && !sel) begin
      if (dbuf_en) m_buf = {m_stage, d};
      else         m_act = {m_stage, d};
    end
    if (w && sel) m_stage = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; upd_stb = 0;
    chk(cmp_buf == m_buf, {req, " buf"}, cmp_buf, m_buf);
    chk(cmp_act == m_act, {req, " act"}, cmp_act, m_act);
    chk(rd_data == m_rd, {req, " rd"}, {8'h0, rd_data}, {8'h0, m_rd});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; rd_en = 0; upd_stb = 0; dbuf_en = 0; byte_sel = 0; wr_data = 0;
    m_stage = 0; m_buf = 0; m_act = 0; m_rd = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1: everything zero after reset
    chk(cmp_buf == 16'h0, "R1 buf", cmp_buf, 16'h0);
    chk(cmp_act == 16'h0, "R1 act", cmp_act, 16'h0);
    chk(rd_data == 8'h0, "R1 rd", {8'h0, rd_data}, 16'h0);
    step(0, 1, 8'h00, 1, 0, "R1 read hi");

    // Sweep both modes over staged / written values
    for (int mode = 0; mode < 2; mode++) begin
      dbuf_en = mode[0];
      for (int h = 0; h < 256; h += 17) begin
        for (int l = 3; l < 256; l += 29) begin
          step(1, 1, 8'(h), 0, 0, "R2 hi write");
          step(1, 0, 8'(l), 0, 0, mode ? "R4 buffered commit" : "R3 direct commit");
          step(0, 0, 8'h00, 1, 0, "R7 read lo");
          step(0, 1, 8'h00, 1, 0, "R7 read hi");
          step(0, 0, 8'h00, 0, 1, mode ? "R5 transfer" : "R5 strobe ignored");
          step(0, 0, 8'h00, 0, 0, "R8 idle hold");
        end
      end
    end

    // R6: staged byte reused by consecutive low writes
    dbuf_en = 0;
    step(1, 1, 8'hA5, 0, 0, "R6 stage");
    step(1, 0, 8'h11, 0, 0, "R6 first low");
    step(1, 0, 8'h22, 0, 0, "R6 second low");
    chk(cmp_act == 16'hA522, "R6 reuse", cmp_act, 16'hA522);

    // R5: update and buffer write in same cycle
    dbuf_en = 1;
    step(1, 1, 8'h3C, 0, 0, "R5 stage");
    step(1, 0, 8'h77, 0, 0, "R5 prep buf");
    step(1, 0, 8'h99, 0, 1, "R5 simultaneous");
    chk(cmp_act == 16'h3C77, "R5 old buf to act", cmp_act, 16'h3C77);
    chk(cmp_buf == 16'h3C99, "R5 new buf", cmp_buf, 16'h3C99);

    // R7: stage not visible, mode selects source, hold without strobe
    step(1, 1, 8'hEE, 0, 0, "R7 stage only");
    step(0, 1, 8'h00, 1, 0, "R7 buf hi not stage");
    chk(rd_data == 8'h3C, "R7 buf hi", {8'h0, rd_data}, 16'h003C);
    dbuf_en = 0;
    step(0, 0, 8'h00, 1, 0, "R7 act lo");
    step(0, 1, 8'h00, 0, 0, "R7 hold");
    chk(rd_data == 8'h77, "R7 hold value", {8'h0, rd_data}, 16'h0077);

    // R8: repeated reads leave registers unchanged
    for (int k = 0; k < 8; k++) step(0, k[0], 8'h00, 1, 0, "R8 read no effect");

    // R1: reset mid-operation
    rst = 1; @(negedge clk); rst = 0;
    m_stage = 0; m_buf = 0; m_act = 0; m_rd = 0;
    chk(cmp_act == 16'h0, "R1 re-reset act", cmp_act, 16'h0);
    chk(cmp_buf == 16'h0, "R1 re-reset buf", cmp_buf, 16'h0);
    step(1, 0, 8'h5A, 0, 0, "R1 stage cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule